// File: doc/BRIEF.md
# Vertex Attribute Offset Generator

This block lays out the attributes of one vertex buffer. It takes an ordered list of up to `MAX_ATTR` attribute descriptors. Each descriptor is a 4-bit kind code and a 2-bit component count. The block walks the list and gives every attribute an aligned byte offset inside the vertex.

- Data kinds are placed on a multiple of their element size.
- Padding kinds are always placed on a 4-byte boundary.
- Each entry adds its own byte size to a running vertex size.

A one-cycle start pulse latches the whole configuration. The block then emits one offset per accepted beat on a valid/ready stream. After that it raises a one-cycle done flag, together with the final vertex size and an error flag.

The error flag covers four cases:
- the configured stride does not equal the laid-out size (the stride is compared as given, not rounded);
- a reserved kind code appears in the list;
- the running size overflows;
- the attribute count is too large.

A stride larger than the data can only be matched by inserting padding entries into the list.

Top module: `vtx_attr_offset_gen`

## Requirements
- R1: Data kinds 0 and 1 have 1-byte elements, kind 2 has 2-byte elements and kind 3 has 4-byte elements. A data attribute's offset is the running size rounded up to a multiple of its element size.
- R2: Kinds 12 to 15 are padding. A padding entry's offset is the running size rounded up to a multiple of 4, and it adds (kind − 11) × 4 bytes.
- R3: The count field holds the component count minus one (0 → 1 component, 3 → 4 components). A data attribute ends at its offset plus element size × component count.
- R4: `vtx_size_o` equals the end of the last entry, with no further rounding. `error_o` is 1 when that size differs from the latched stride.
- R5: Kinds 4 to 11 are reserved. Such an entry sets the error flag, adds no bytes, and reports the current running size as its offset.
- R6: Entries are reported in list order, one per valid/ready handshake, with `ofs_index_o` counting 0, 1, 2 and so on. `ofs_valid_o` and `done_o` are never high together.
- R7: While `ofs_valid_o` is high and `ofs_ready_i` is low, the offset and the index do not change.
- R8: `done_o` is a one-cycle pulse in the cycle after the last handshake. `vtx_size_o` and `error_o` hold their values until the next start.
- R9: If an entry would end beyond 2^OFS_W − 1, the error flag is set and the running size saturates at 2^OFS_W − 1.
- R10: A count of 0 produces no beats, and `done_o` rises in the cycle after start with a size of 0. A count above `MAX_ATTR` is treated as `MAX_ATTR` and sets the error flag.
- R11: The configuration is latched at start. A start pulse or a change of the inputs while a walk is in progress has no effect on that walk.
- R12: After reset, `ofs_valid_o` and `done_o` are 0, and `vtx_size_o` and `error_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a walk; latches the configuration |
| attr_num_i | input | NUM_W | Number of entries in the list |
| attr_kind_i | input | MAX_ATTR*4 | Kind code per entry; entry i is in bits [4i+3:4i] |
| attr_cnt_i | input | MAX_ATTR*2 | Component count minus one per entry; entry i is in bits [2i+1:2i] |
| stride_i | input | OFS_W | Configured vertex stride in bytes |
| ofs_valid_o | output | 1 | An offset is presented |
| ofs_ready_i | input | 1 | The consumer accepts the offset |
| ofs_index_o | output | IDX_W | List position of the presented entry |
| ofs_value_o | output | OFS_W | Byte offset of the presented entry |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| error_o | output | 1 | Walk error (stride mismatch, reserved kind, overflow or count too large) |
| vtx_size_o | output | OFS_W | Final laid-out vertex size |

## Verification
Some properties are checked by assertions on every cycle:
- the presented offset stays stable while the consumer stalls;
- the index steps by one per handshake;
- the done pulse lasts one cycle and never coincides with a valid beat;
- 2- and 4-byte data offsets and padding offsets are aligned;
- a size that differs from the stride at done always shows as an error.

The exact offset values, the saturation on overflow, the handling of reserved kinds, and the behaviour of empty and oversized lists can only be shown by the bench. It compares every beat against a layout computed arithmetically, across a sweep of every kind and count code and across mixed lists. The bench also shows that a start pulse during a walk has no effect.

// File: rtl/vaog_pkg.sv
package vaog_pkg;

    localparam int KIND_W   = 4;
    localparam int CNT_W    = 2;
    localparam int BYTES_W  = 5;
    localparam logic [KIND_W-1:0] LAST_DATA_KIND = 4'd3;
    localparam logic [KIND_W-1:0] PAD_FLOOR      = 4'd11;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [CNT_W-1:0]  cnt_m1;
    } attr_desc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EMIT,
        ST_FINISH
    } walk_state_e;

    function automatic logic kind_is_pad(input logic [KIND_W-1:0] k);
        return k > PAD_FLOOR;
    endfunction

    function automatic logic kind_is_rsv(input logic [KIND_W-1:0] k);
        return (k > LAST_DATA_KIND) && (k <= PAD_FLOOR);
    endfunction

    // log2 of the element size of a data kind
    function automatic logic [1:0] kind_elem_lg(input logic [KIND_W-1:0] k);
        case (k)
            4'd2:    return 2'd1;
            4'd3:    return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/vaog_desc_store.sv
module vaog_desc_store
    import vaog_pkg::*;
#(
    parameter int MAX_ATTR = 12,
    localparam int IDX_W = $clog2(MAX_ATTR)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [MAX_ATTR*KIND_W-1:0] kinds,
    input  logic [MAX_ATTR*CNT_W-1:0]  cnts,
    input  logic [IDX_W-1:0]           sel,
    output attr_desc_t                 desc
);

    attr_desc_t slot [MAX_ATTR];

    for (genvar g = 0; g < MAX_ATTR; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (load) begin
                slot[g].kind   <= kinds[g*KIND_W +: KIND_W];
                slot[g].cnt_m1 <= cnts[g*CNT_W +: CNT_W];
            end
        end
    end

    always_comb begin
        desc = '0;
        for (int i = 0; i < MAX_ATTR; i++) begin
            if (sel == IDX_W'(i)) desc = slot[i];
        end
    end

endmodule

// File: rtl/vaog_attr_sizer.sv
module vaog_attr_sizer
    import vaog_pkg::*;
#(
    parameter int OFS_W = 8,
    localparam int EXT_W = OFS_W + 1
) (
    input  attr_desc_t       desc,
    input  logic [OFS_W-1:0] run,
    output logic [EXT_W-1:0] place,
    output logic [EXT_W-1:0] stop,
    output logic             reserved
);

    logic [1:0]         align_lg;
    logic [BYTES_W-1:0] nbytes;
    logic [EXT_W-1:0]   mask;

    always_comb begin
        reserved = kind_is_rsv(desc.kind);
        if (kind_is_pad(desc.kind)) begin
            align_lg = 2'd2;
            nbytes   = {BYTES_W'(desc.kind - PAD_FLOOR)} << 2;
        end else if (reserved) begin
            align_lg = 2'd0;
            nbytes   = '0;
        end else begin
            align_lg = kind_elem_lg(desc.kind);
            nbytes   = BYTES_W'({1'b0, desc.cnt_m1} + 3'd1) << align_lg;
        end
        mask  = EXT_W'((3'd1 << align_lg) - 3'd1);
        place = ({1'b0, run} + mask) & ~mask;
        stop  = place + EXT_W'(nbytes);
    end

endmodule

// File: rtl/vtx_attr_offset_gen.sv
module vtx_attr_offset_gen
    import vaog_pkg::*;
#(
    parameter int MAX_ATTR = 12,
    parameter int OFS_W    = 8,
    localparam int NUM_W = $clog2(MAX_ATTR + 1),
    localparam int IDX_W = $clog2(MAX_ATTR),
    localparam int EXT_W = OFS_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [NUM_W-1:0]           attr_num_i,
    input  logic [MAX_ATTR*KIND_W-1:0] attr_kind_i,
    input  logic [MAX_ATTR*CNT_W-1:0]  attr_cnt_i,
    input  logic [OFS_W-1:0]           stride_i,
    output logic                       ofs_valid_o,
    input  logic                       ofs_ready_i,
    output logic [IDX_W-1:0]           ofs_index_o,
    output logic [OFS_W-1:0]           ofs_value_o,
    output logic                       done_o,
    output logic                       error_o,
    output logic [OFS_W-1:0]           vtx_size_o
);

    walk_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic [NUM_W-1:0] num_q;
    logic [OFS_W-1:0] run_q;
    logic [OFS_W-1:0] stride_q;
    logic             err_q;

    attr_desc_t       cur_desc;
    logic [KIND_W-1:0] cur_kind;
    logic [EXT_W-1:0] place, stop;
    logic             reserved;
    logic             launch, too_many, last_beat, spill;

    assign launch    = (state_q == ST_IDLE) && start_i;
    assign too_many  = attr_num_i > NUM_W'(MAX_ATTR);
    assign last_beat = (NUM_W'(idx_q) + NUM_W'(1)) >= num_q;
    assign spill     = stop[OFS_W];
    assign cur_kind  = cur_desc.kind;

    vaog_desc_store #(.MAX_ATTR(MAX_ATTR)) u_store (
        .clk   (clk),
        .rst   (rst),
        .load  (launch),
        .kinds (attr_kind_i),
        .cnts  (attr_cnt_i),
        .sel   (idx_q),
        .desc  (cur_desc)
    );

    vaog_attr_sizer #(.OFS_W(OFS_W)) u_sizer (
        .desc     (cur_desc),
        .run      (run_q),
        .place    (place),
        .stop     (stop),
        .reserved (reserved)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            num_q    <= '0;
            run_q    <= '0;
            stride_q <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        idx_q    <= '0;
                        run_q    <= '0;
                        stride_q <= stride_i;
                        num_q    <= too_many ? NUM_W'(MAX_ATTR) : attr_num_i;
                        err_q    <= too_many;
                        state_q  <= (attr_num_i == '0) ? ST_FINISH : ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (ofs_ready_i) begin
                        run_q <= spill ? {OFS_W{1'b1}} : stop[OFS_W-1:0];
                        err_q <= err_q | reserved | spill;
                        idx_q <= idx_q + IDX_W'(1);
                        if (last_beat) state_q <= ST_FINISH;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ofs_valid_o = (state_q == ST_EMIT);
    assign ofs_index_o = idx_q;
    assign ofs_value_o = place[OFS_W-1:0];
    assign done_o      = (state_q == ST_FINISH);
    assign vtx_size_o  = run_q;
    assign error_o     = err_q | (run_q != stride_q);

endmodule

// File: rtl/vaog_checker.sv
module vaog_checker #(
    parameter int OFS_W = 8,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             valid,
    input logic             ready,
    input logic [IDX_W-1:0] index,
    input logic [OFS_W-1:0] value,
    input logic             done,
    input logic             error,
    input logic [OFS_W-1:0] size,
    input logic [OFS_W-1:0] stride_held,
    input logic [3:0]       cur_kind
);

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(value) && $stable(index)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        valid |-> !done); // R6

    AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
        valid && ready |=> done || (valid && index == IDX_W'($past(index) + 1'b1))); // R6

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        valid && cur_kind == 4'd3 |-> value[1:0] == 2'b00); // R1

    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (rst)
        valid && cur_kind == 4'd2 |-> value[0] == 1'b0); // R1

    AST_PAD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        valid && cur_kind > 4'd11 |-> value[1:0] == 2'b00); // R2

    AST_STRIDE_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        done && size != stride_held |-> error); // R4

endmodule

bind vtx_attr_offset_gen vaog_checker #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_vaog_checker (
    .clk         (clk),
    .rst         (rst),
    .valid       (ofs_valid_o),
    .ready       (ofs_ready_i),
    .index       (ofs_index_o),
    .value       (ofs_value_o),
    .done        (done_o),
    .error       (error_o),
    .size        (vtx_size_o),
    .stride_held (stride_q),
    .cur_kind    (cur_kind)
);

// File: tb/test_vtx_attr_offset_gen.sv
`timescale 1ns/1ps
module test_vtx_attr_offset_gen;

    localparam int MAXA  = 12;
    localparam int OW    = 7;
    localparam int NW    = $clog2(MAXA + 1);
    localparam int IW    = $clog2(MAXA);
    localparam int LIMIT = (1 << OW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [NW-1:0]     attr_num_i = '0;
    logic [MAXA*4-1:0] attr_kind_i = '0;
    logic [MAXA*2-1:0] attr_cnt_i = '0;
    logic [OW-1:0]     stride_i = '0;
    logic              ofs_ready_i = 1'b1;
    logic              ofs_valid_o, done_o, error_o;
    logic [IW-1:0]     ofs_index_o;
    logic [OW-1:0]     ofs_value_o, vtx_size_o;

    int n_tests = 0;
    int n_fail  = 0;

    int  t_kind [MAXA];
    int  t_cnt  [MAXA];
    int  t_num;
    int  t_stride;
    int  exp_off [MAXA];
    int  exp_size;
    bit  exp_err;
    int  exp_beats;

    always #2 clk = ~clk;

    vtx_attr_offset_gen #(.MAX_ATTR(MAXA), .OFS_W(OW)) i_vtx_attr_offset_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .attr_num_i(attr_num_i),
        .attr_kind_i(attr_kind_i), .attr_cnt_i(attr_cnt_i), .stride_i(stride_i),
        .ofs_valid_o(ofs_valid_o), .ofs_ready_i(ofs_ready_i), .ofs_index_o(ofs_index_o),
        .ofs_value_o(ofs_value_o), .done_o(done_o), .error_o(error_o), .vtx_size_o(vtx_size_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Independent arithmetic layout model
    task automatic model();
        int n, run, al, by, off, stop;
        n = (t_num > MAXA) ? MAXA : t_num;
        exp_err = (t_num > MAXA);
        exp_beats = n;
        run = 0;
        for (int i = 0; i < n; i++) begin
            if (t_kind[i] > 11) begin
                al = 4; by = (t_kind[i] - 11) * 4;
            end else if (t_kind[i] <= 3) begin
                al = (t_kind[i] == 3) ? 4 : ((t_kind[i] == 2) ? 2 : 1);
                by = al * (t_cnt[i] + 1);
            end else begin
                al = 1; by = 0; exp_err = 1;
            end
            off  = ((run + al - 1) / al) * al;
            stop = off + by;
            exp_off[i] = off % (LIMIT + 1);
            if (stop > LIMIT) begin
                exp_err = 1; run = LIMIT;
            end else begin
                run = stop;
            end
        end
        exp_size = run;
        if (run != t_stride) exp_err = 1;
    endtask

    task automatic run_case(input bit stall, input bit poke);
        int beat, cycles;
        bit done_seen, stalled, poked;
        model();
        @(negedge clk);
        for (int i = 0; i < MAXA; i++) begin
            attr_kind_i[i*4 +: 4] = 4'(t_kind[i]);
            attr_cnt_i[i*2 +: 2]  = 2'(t_cnt[i]);
        end
        attr_num_i = NW'(t_num);
        stride_i   = OW'(t_stride);
        start_i    = 1'b1;
        ofs_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        beat = 0; cycles = 0; done_seen = 0; stalled = 0; poked = 0;
        while (!done_seen && cycles < 400) begin
            start_i = 1'b0;
            if (poke && beat == 1 && !poked) begin
                // R11: restart and config change during a walk must be ignored
                start_i = 1'b1;
                attr_kind_i = '1;
                stride_i = '0;
                attr_num_i = '0;
                poked = 1;
            end
            if (ofs_valid_o) begin
                chk(beat < exp_beats, "R6 beat count", beat, exp_beats);
                if (beat < exp_beats) begin
                    chk(ofs_index_o == IW'(beat), "R6 index order", ofs_index_o, beat);
                    chk(ofs_value_o == OW'(exp_off[beat]),
                        stalled ? "R7 offset under stall" : "R1/R2/R3/R5 offset",
                        ofs_value_o, exp_off[beat]);
                end
                if (stall && !stalled && (beat % 2 == 0)) begin
                    ofs_ready_i = 1'b0; stalled = 1;
                end else begin
                    ofs_ready_i = 1'b1; stalled = 0; beat++;
                end
            end
            if (done_o) begin
                chk(beat == exp_beats, "R8/R10 done after last beat", beat, exp_beats);
                chk(vtx_size_o == OW'(exp_size), "R4/R9 final size", vtx_size_o, exp_size);
                chk(error_o == exp_err, "R4/R5/R9 error flag", error_o, exp_err);
                done_seen = 1;
                ofs_ready_i = 1'b1;
            end
            @(negedge clk);
            cycles++;
        end
        start_i = 1'b0;
        chk(done_seen, "R8 done reached", done_seen, 1);
        @(negedge clk);
        chk(!done_o, "R8 done one cycle", done_o, 0);
        chk(vtx_size_o == OW'(exp_size) && error_o == exp_err, "R8 results held",
            vtx_size_o, exp_size);
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < MAXA; i++) begin
            t_kind[i] = 0; t_cnt[i] = 0;
        end
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'h1d5a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!ofs_valid_o && !done_o, "R12 idle outputs", ofs_valid_o, 0);
        chk(vtx_size_o == '0 && !error_o, "R12 size and error", vtx_size_o, 0);

        // Sweep of every kind and count after a one-byte lead entry
        for (int k = 0; k < 16; k++) begin
            for (int c = 0; c < 4; c++) begin
                clear_cfg();
                t_num = 2; t_kind[1] = k; t_cnt[1] = c; t_stride = 0;
                model();
                t_stride = ((k + c) % 3 == 0) ? exp_size + 1 : exp_size;
                run_case((k % 2) == 1, 1'b0);
            end
        end

        // R10 empty list, matching and mismatched stride
        clear_cfg(); t_num = 0; t_stride = 0; run_case(1'b0, 1'b0);
        clear_cfg(); t_num = 0; t_stride = 5; run_case(1'b0, 1'b0);
        // R10 oversized count clamps to MAXA and flags error
        clear_cfg(); t_num = 15; t_stride = 12; run_case(1'b0, 1'b0);
        // R9 overflow: twelve 16-byte pads exceed the 7-bit range
        clear_cfg(); t_num = 12;
        for (int i = 0; i < MAXA; i++) t_kind[i] = 15;
        t_stride = LIMIT; run_case(1'b0, 1'b0);
        // R11 start and input change during walk, with stalls
        clear_cfg(); t_num = 4; t_kind[0] = 1; t_kind[1] = 3; t_cnt[1] = 2;
        t_kind[2] = 2; t_kind[3] = 13; t_stride = 24;
        run_case(1'b1, 1'b1);

        // Mixed lists
        for (int r = 0; r < 40; r++) begin
            int pick;
            clear_cfg();
            t_num = 1 + ($urandom(seed + r) % MAXA);
            for (int i = 0; i < MAXA; i++) begin
                pick = $urandom % 8;
                t_kind[i] = (pick < 4) ? pick : pick + 8;
                t_cnt[i]  = $urandom % 4;
            end
            if (r % 10 == 7) t_kind[0] = 6;
            t_stride = 0;
            model();
            t_stride = (r % 4 == 1) ? (exp_size ^ 1) : exp_size;
            run_case(r % 3 == 0, r % 5 == 2 && t_num > 2);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule